// File: doc/BRIEF.md
# Fixed-Period Encoder Speed and Position Capture

This block sits behind a quadrature decoder. It takes one count pulse per decoded encoder edge, together with a direction bit, and runs three counters. The first is a free-running time base that advances once per clock. The second is an edge counter that only counts up. The third is a position counter that counts up or down. An auxiliary register stamps the time base on every encoder edge. A single-cycle sample strobe from the host freezes four 32-bit words together, so each snapshot is consistent:

- the edge count;
- the time stamp of the most recent edge;
- the position;
- the time base at the sample instant.

The stamp of the last edge passes through two register stages: it is first captured at the edge, then copied at the sample. Because of this, every fixed sample period yields a usable result, even when no edge arrived in that period. The host forms differences between successive snapshots. Speed is the ratio of the edge-count difference to the edge-time difference. The gap from the last edge to the sample instant refines the position estimate. All arithmetic beyond counting is left to the host. Clear and preset strobes re-zero the position counter or load it.

Top module: `mt_capture`

## Requirements
- R1: After reset all four snapshot outputs read zero.
- R2: The time base starts at zero once reset is released and advances by one every clock, modulo 2^32. `smp_time` holds the time-base value present in the cycle the sample strobe was high.
- R3: The edge count rises by exactly one for every cycle with `cnt_pulse` high. It is unaffected by `cnt_dir`, `pos_clr` and `pos_load`.
- R4: On a count pulse, position rises by one when `cnt_dir` is 1 and falls by one when it is 0, wrapping modulo 2^32 (0xFFFFFFFF+1 = 0, 0-1 = 0xFFFFFFFF).
- R5: `pos_clr` sets the position to zero on the next clock, overriding any count pulse in the same cycle.
- R6: `pos_load` sets the position to `load_val` on the next clock, overriding a count pulse. When `pos_clr` is also high, the clear wins.
- R7: Each count pulse stamps the time-base value of its cycle. `last_edge_time` reports the stamp of the most recent pulse at or before the sample, and keeps the older stamp when no pulse occurred in the period.
- R8: The four snapshot outputs change only on the clock edge that ends a cycle with `sample` high. They update together and hold otherwise.
- R9: A count pulse in the same cycle as `sample` is included in the snapshot: edge count, position and edge stamp all reflect it.
- R10: A clear or load in the same cycle as `sample` is included in the captured position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_pulse | input | 1 | One-cycle pulse per decoded encoder edge |
| cnt_dir | input | 1 | Direction of the pulse: 1 up, 0 down |
| sample | input | 1 | One-cycle snapshot strobe |
| pos_clr | input | 1 | One-cycle position clear |
| pos_load | input | 1 | One-cycle position load |
| load_val | input | 32 | Value taken by a position load |
| edge_count | output | 32 | Snapshot of the edge counter |
| last_edge_time | output | 32 | Snapshot of the time stamp of the last edge |
| position | output | 32 | Snapshot of the position counter |
| smp_time | output | 32 | Snapshot of the time base at the sample |

## Verification
The bench targets the cycles where two events collide. In the first, an edge coincides with the sample; a design that latched the pre-edge counters would give an edge count one short and a stale stamp. In the second, a clear or load coincides with the sample or with a pulse; a wrong priority shows up as a non-zero or off-by-one position. A long edge-free period checks that the old stamp is kept, not replaced by the sample time. Presets near the 32-bit boundary, counted up and down, catch a counter that saturates instead of wrapping. Continuous hold checks between samples catch snapshot words that leak live counter values.

// File: rtl/mt_pkg.sv
package mt_pkg;

  localparam int SNAP_NUM = 4;

  typedef enum logic [1:0] {
    SNAP_EDGES     = 2'd0,
    SNAP_EDGE_TIME = 2'd1,
    SNAP_POS       = 2'd2,
    SNAP_SMP_TIME  = 2'd3
  } snap_idx_e;

  typedef struct packed {
    logic clr;
    logic load;
  } pos_cmd_t;

endpackage

// File: rtl/mt_timebase.sv
module mt_timebase #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pulse,
  output logic [W-1:0] tb_o,
  output logic [W-1:0] stamp_o,
  output logic [W-1:0] stamp_next_o
);

  logic [W-1:0] tb_q, tb_d;
  logic [W-1:0] stamp_q, stamp_d;
  logic         stamp_en;

  always_comb begin
    tb_d     = tb_q + W'(1);
    stamp_en = cnt_pulse;
    stamp_d  = stamp_en ? tb_q : stamp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tb_q <= '0;
    end else begin
      tb_q <= tb_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
    end else if (stamp_en) begin
      stamp_q <= stamp_d;
    end
  end

  assign tb_o         = tb_q;
  assign stamp_o      = stamp_q;
  assign stamp_next_o = stamp_d;

  AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> tb_q == $past(tb_q) + W'(1)); // R2
  AST_STAMP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> stamp_q == $past(tb_q)); // R7
  AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(stamp_q)); // R7

endmodule

// File: rtl/mt_edge_counter.sv
module mt_edge_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pulse,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_next_o
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = cnt_pulse;
    cnt_d  = cnt_en ? cnt_q + W'(1) : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;

  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_pulse |=> cnt_q == $past(cnt_q) + W'(1)); // R3
  AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_pulse |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/mt_pos_counter.sv
module mt_pos_counter
  import mt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pulse,
  input  logic         cnt_dir,
  input  pos_cmd_t     cmd,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] pos_o,
  output logic [W-1:0] pos_next_o
);

  logic [W-1:0] pos_q, pos_d;
  logic         pos_en;

  always_comb begin
    pos_en = cmd.clr | cmd.load | cnt_pulse;
    if (cmd.clr) begin
      pos_d = '0;
    end else if (cmd.load) begin
      pos_d = load_val;
    end else if (cnt_pulse) begin
      pos_d = cnt_dir ? pos_q + W'(1) : pos_q - W'(1);
    end else begin
      pos_d = pos_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (pos_en) begin
      pos_q <= pos_d;
    end
  end

  assign pos_o      = pos_q;
  assign pos_next_o = pos_d;

  AST_POS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clr |=> pos_q == '0); // R5
  AST_POS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.load && !cmd.clr) |=> pos_q == $past(load_val)); // R6
  AST_POS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && cnt_dir && !cmd.clr && !cmd.load) |=> pos_q == $past(pos_q) + W'(1)); // R4
  AST_POS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_pulse && !cnt_dir && !cmd.clr && !cmd.load) |=> pos_q == $past(pos_q) - W'(1)); // R4
  AST_POS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_pulse && !cmd.clr && !cmd.load) |=> $stable(pos_q)); // R4

endmodule

// File: rtl/mt_snapshot.sv
module mt_snapshot #(
  parameter int W = 32,
  parameter int N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample,
  input  logic [N-1:0][W-1:0] din,
  output logic [N-1:0][W-1:0] dout
);

  for (genvar i = 0; i < N; i++) begin : g_word
    logic [W-1:0] word_q, word_d;

    always_comb begin
      word_d = sample ? din[i] : word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (sample) begin
        word_q <= word_d;
      end
    end

    assign dout[i] = word_q;
  end

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample |=> $stable(dout)); // R8
  AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> dout == $past(din)); // R8

endmodule

// File: rtl/mt_capture.sv
module mt_capture
  import mt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_pulse,
  input  logic         cnt_dir,
  input  logic         sample,
  input  logic         pos_clr,
  input  logic         pos_load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] edge_count,
  output logic [W-1:0] last_edge_time,
  output logic [W-1:0] position,
  output logic [W-1:0] smp_time
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [W-1:0] tb, stamp, stamp_next;
  logic [W-1:0] edges, edges_next;
  logic [W-1:0] pos, pos_next;
  pos_cmd_t     cmd;

  assign cmd.clr  = pos_clr;
  assign cmd.load = pos_load;

  mt_timebase #(.W(W)) u_timebase (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cnt_pulse    (cnt_pulse),
    .tb_o         (tb),
    .stamp_o      (stamp),
    .stamp_next_o (stamp_next)
  );

  mt_edge_counter #(.W(W)) u_edges (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cnt_pulse  (cnt_pulse),
    .cnt_o      (edges),
    .cnt_next_o (edges_next)
  );

  mt_pos_counter #(.W(W)) u_pos (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cnt_pulse  (cnt_pulse),
    .cnt_dir    (cnt_dir),
    .cmd        (cmd),
    .load_val   (load_val),
    .pos_o      (pos),
    .pos_next_o (pos_next)
  );

  logic [SNAP_NUM-1:0][W-1:0] snap_in, snap_out;

  always_comb begin
    snap_in                 = '0;
    snap_in[SNAP_EDGES]     = edges_next;
    snap_in[SNAP_EDGE_TIME] = stamp_next;
    snap_in[SNAP_POS]       = pos_next;
    snap_in[SNAP_SMP_TIME]  = tb;
  end

  mt_snapshot #(.W(W), .N(SNAP_NUM)) u_snap (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sample (sample),
    .din    (snap_in),
    .dout   (snap_out)
  );

  assign edge_count     = snap_out[SNAP_EDGES];
  assign last_edge_time = snap_out[SNAP_EDGE_TIME];
  assign position       = snap_out[SNAP_POS];
  assign smp_time       = snap_out[SNAP_SMP_TIME];

  AST_SNAP_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample && cnt_pulse) |=> edge_count == $past(edges) + W'(1)); // R9
  AST_STAMP_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample && cnt_pulse) |=> last_edge_time == $past(tb)); // R9
  AST_SNAP_WITH_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sample && pos_clr) |=> position == '0); // R10
  AST_SMP_TIME: assert property (@(posedge clk) disable iff (!rst_int_n)
    sample |=> smp_time == $past(tb)); // R2

endmodule

// File: tb/mt_capture_bench.sv
module mt_capture_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_pulse = 1'b0;
  logic        cnt_dir = 1'b0;
  logic        sample = 1'b0;
  logic        pos_clr = 1'b0;
  logic        pos_load = 1'b0;
  logic [31:0] load_val = '0;
  logic [31:0] edge_count, last_edge_time, position, smp_time;

  always #4 clk = ~clk;

  mt_capture u_mt_capture (
    .clk            (clk),
    .rst_n          (rst_n),
    .cnt_pulse      (cnt_pulse),
    .cnt_dir        (cnt_dir),
    .sample         (sample),
    .pos_clr        (pos_clr),
    .pos_load       (pos_load),
    .load_val       (load_val),
    .edge_count     (edge_count),
    .last_edge_time (last_edge_time),
    .position       (position),
    .smp_time       (smp_time)
  );

  typedef struct {
    int          due;
    logic [31:0] e, et, p, st;
  } snap_t;

  snap_t       exp_q[$];
  snap_t       cur;
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  logic [31:0] m_edges = '0, m_stamp = '0, m_pos = '0;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected snapshot.
  task automatic step(input logic e, input logic d, input logic s,
                      input logic c, input logic l, input logic [31:0] v);
    logic [31:0] tbv, n_edges, n_stamp, n_pos;
    snap_t it;
    @(negedge clk);
    cnt_pulse = e; cnt_dir = d; sample = s; pos_clr = c; pos_load = l; load_val = v;
    tbv     = 32'(cyc - 2);
    n_edges = e ? m_edges + 32'd1 : m_edges;
    n_stamp = e ? tbv : m_stamp;
    if (c)      n_pos = '0;
    else if (l) n_pos = v;
    else if (e) n_pos = d ? m_pos + 32'd1 : m_pos - 32'd1;
    else        n_pos = m_pos;
    if (s) begin
      it.due = cyc + 1; it.e = n_edges; it.et = n_stamp; it.p = n_pos; it.st = tbv;
      exp_q.push_back(it);
    end
    m_edges = n_edges; m_stamp = n_stamp; m_pos = n_pos;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0);
  endtask

  // Monitor: outputs must equal the latest due snapshot every cycle (R8 hold).
  initial begin
    cur = '{due: 0, e: '0, et: '0, p: '0, st: '0};
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (exp_q.size() > 0 && exp_q[0].due == cyc) cur = exp_q.pop_front();
        check("R3", "edge_count", edge_count, cur.e);
        check("R7", "last_edge_time", last_edge_time, cur.et);
        check("R4", "position", position, cur.p);
        check("R2", "smp_time", smp_time, cur.st);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state at the ports
    check("R1", "edge_count reset", edge_count, '0);
    check("R1", "last_edge_time reset", last_edge_time, '0);
    check("R1", "position reset", position, '0);
    check("R1", "smp_time reset", smp_time, '0);
    mon_on = 1'b1;
    idle(3);
    step(0, 0, 1, 0, 0, '0);                 // R2 first sample, no edges
    // R3 R4 forward edges
    for (int i = 0; i < 5; i++) begin step(1, 1, 0, 0, 0, '0); idle(2); end
    step(0, 0, 1, 0, 0, '0);
    // R4 reverse edges, direction ignored by edge counter (R3)
    for (int i = 0; i < 3; i++) begin step(1, 0, 0, 0, 0, '0); idle(1); end
    step(0, 0, 1, 0, 0, '0);
    // R7 edge-free period keeps the old stamp
    idle(12);
    step(0, 0, 1, 0, 0, '0);
    // R9 edge in the sample cycle
    idle(2);
    step(1, 1, 1, 0, 0, '0);
    idle(2);
    // R6 load then count up
    step(0, 0, 0, 0, 1, 32'h0000_1234);
    step(1, 1, 0, 0, 0, '0);
    step(1, 1, 0, 0, 0, '0);
    step(0, 0, 1, 0, 0, '0);
    // R6 clear beats load; R5 clear beats a pulse
    step(0, 0, 0, 1, 1, 32'hDEAD_BEEF);
    step(0, 0, 1, 0, 0, '0);
    step(0, 0, 0, 0, 1, 32'h0000_0077);
    step(1, 1, 0, 1, 0, '0);
    step(0, 0, 1, 0, 0, '0);
    // R6 load beats a pulse
    step(1, 0, 0, 0, 1, 32'h0000_0500);
    step(0, 0, 1, 0, 0, '0);
    // R10 load and clear in the sample cycle
    step(0, 0, 1, 0, 1, 32'hCAFE_0001);
    idle(1);
    step(1, 1, 1, 1, 0, '0);
    idle(1);
    // R4 wrap up and down
    step(0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    step(1, 1, 1, 0, 0, '0);
    step(1, 0, 1, 0, 0, '0);
    step(1, 0, 1, 0, 0, '0);
    // R8 back-to-back samples with steady edges
    for (int i = 0; i < 6; i++) step(i[0], 1, 1, 0, 0, '0);
    idle(4);
    finish_run();
  end

endmodule